// File: doc/BRIEF.md
# Dual-Context Program Counter Switch

This block sits beside one processing element of a video filtering array. The element's 512-word instruction memory holds two resident programs side by side: the program for 16x16 coding blocks fills words 0 to 254, and the program for 8x8 coding blocks fills words 255 to 511. A small data store keeps one start-address word for each program and a status word that records which block size last completed. A global controller talks to the block over one command port. A collect command asks the block to report its status word. A configure command carries a block-size code and starts the next block in that mode.

The program counter is rewritten with the matching start address only when the requested mode differs from the mode in force. If the mode is unchanged, the block starts with the counter left where it is, so only data moves. A block stays busy until the output element returns the completion token 222 on the handshake input. A configure command that arrives during a busy block is held, and the newest one wins. It is applied in the cycle after the block finishes. A configure command with an unknown code is dropped, and the block flags an error for one cycle.

Top module: `pcs_top`

## Requirements
- R1: While reset is asserted, and afterwards until the first valid configure command, `pc` is 0, `blk_busy`, `pc_load`, `rpt_valid` and `cfg_err` are 0, and the status word reads 0.
- R2: A configure command (`cmd_valid`=1, `cmd_kind`=1) with code 1 (16x16) or code 2 (8x8), issued while idle in a different mode, makes `pc` equal to that mode's start word one cycle later. The start word is 0 for code 1 and 255 for code 2. In that same cycle `pc_load` is 1 and `blk_busy` is 1.
- R3: A configure command whose code equals the mode already in force starts a block (`blk_busy`=1) without a `pc_load` pulse and leaves `pc` unchanged.
- R4: A configure command with code 0 or 3 raises `cfg_err` for exactly one cycle, one cycle after the command. It changes neither `pc`, `blk_busy`, the held command nor the status word.
- R5: A collect command (`cmd_valid`=1, `cmd_kind`=0) produces `rpt_valid`=1 for one cycle, one cycle later. `rpt_code` then carries the status word as it stood when the command was taken.
- R6: The status word takes the mode code of a block only when that block completes. Starting a block does not change it.
- R7: While busy, `hs_valid`=1 with `hs_word`=222 clears `blk_busy` one cycle later. Any other handshake word, and any handshake while idle, has no effect.
- R8: A valid configure command that arrives while busy is held, and a later one replaces it. It is applied, with R2 or R3 behaviour, one cycle after `blk_busy` clears. A command that arrives in the same cycle as the completion token is held as well.
- R9: Every value loaded into `pc` is the first word of one of the two contexts, 0 or 255, and so lies inside the 512-word instruction memory.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command strobe from the global controller |
| cmd_kind | input | 1 | 0 = collect status, 1 = configure |
| cmd_code | input | 2 | Block-size code for configure: 1 = 16x16, 2 = 8x8 |
| hs_valid | input | 1 | Handshake strobe from the output element |
| hs_word | input | 8 | Handshake value; 222 marks block completion |
| pc | output | 9 | Program counter start pointer into instruction memory |
| pc_load | output | 1 | One-cycle pulse when `pc` was rewritten by a context switch |
| blk_busy | output | 1 | A block is in progress |
| rpt_valid | output | 1 | Status report strobe |
| rpt_code | output | 2 | Reported status word (block size last completed) |
| cfg_err | output | 1 | One-cycle pulse for a configure command with an unknown code |

## Verification
The hardest case to reach is a completion token that coincides with a new configure command, followed by the deferred command switching context in the next cycle. The stimulus first makes the block busy in 8x8 mode. It then sends the token 222 and a 16x16 configure command in the same cycle, and checks that the counter moves to 0 with a load pulse exactly one cycle after busy drops. A second sequence stacks two configure commands and an invalid code during one busy block. This shows that the newest valid command wins, that the invalid one leaves the held command alone, and that a held same-mode command starts a block without touching the counter.

// File: rtl/pcs_pkg.sv
// Package: shared constants and types for the dual-context program counter switch.
// Assumes a single processing element with one instruction memory split into two contexts.
package pcs_pkg;
    localparam int CODE_W = 2;
    typedef enum logic [CODE_W-1:0] {
        MODE_NONE = 2'd0,
        MODE_BIG  = 2'd1,
        MODE_SML  = 2'd2,
        MODE_BAD  = 2'd3
    } mode_e;

    typedef enum logic {
        CMD_COLLECT = 1'b0,
        CMD_CONFIG  = 1'b1
    } cmd_e;
endpackage

// File: rtl/pcs_mode_decode.sv
// Mode decoder: maps a block-size code to its start-flag address in the data store.
// Assumes only the two resident context codes are legal; all others are flagged.
module pcs_mode_decode
    import pcs_pkg::*;
#(
    parameter int AW          = 9,
    parameter int FLAG_A_ADDR = 500,
    parameter int FLAG_B_ADDR = 501
) (
    input  logic [CODE_W-1:0] code,
    output logic              known,
    output logic [AW-1:0]     flag_addr
);
    // Decode the code into a legality bit and the flag word address.
    always_comb begin
        known     = 1'b0;
        flag_addr = '0;
        case (mode_e'(code))
            MODE_BIG: begin
                known     = 1'b1;
                flag_addr = AW'(FLAG_A_ADDR);
            end
            MODE_SML: begin
                known     = 1'b1;
                flag_addr = AW'(FLAG_B_ADDR);
            end
            default: begin
                known     = 1'b0;
                flag_addr = '0;
            end
        endcase
    end
endmodule

// File: rtl/pcs_flag_store.sv
// Flag store: the data-memory words this controller uses, two start flags and one status word.
// Assumes the start flags are fixed after reset; only the status word is written.
module pcs_flag_store #(
    parameter int AW          = 9,
    parameter int DW          = 9,
    parameter int FLAG_A_ADDR = 500,
    parameter int FLAG_B_ADDR = 501,
    parameter int STAT_ADDR   = 510,
    parameter int FLAG_A_VAL  = 0,
    parameter int FLAG_B_VAL  = 255
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    input  logic          st_we,
    input  logic [DW-1:0] st_wdata,
    output logic [DW-1:0] st_q
);
    localparam int NWORDS = 3;
    localparam logic [NWORDS*AW-1:0] ADDRS =
        {AW'(STAT_ADDR), AW'(FLAG_B_ADDR), AW'(FLAG_A_ADDR)};

    logic [DW-1:0] words [NWORDS];

    // Hold the flag words at their start values and update the status word on request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            words[0] <= DW'(FLAG_A_VAL);
            words[1] <= DW'(FLAG_B_VAL);
            words[2] <= '0;
        end else if (st_we) begin
            words[2] <= st_wdata;
        end
    end

    logic [NWORDS-1:0] hit;
    genvar gi;
    generate
        for (gi = 0; gi < NWORDS; gi++) begin : g_hit
            assign hit[gi] = (rd_addr == ADDRS[gi*AW +: AW]);
        end
    endgenerate

    // Select the addressed word; unmapped addresses read as zero.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NWORDS; i++) begin
            if (hit[i]) rd_data = words[i];
        end
    end

    assign st_q = words[2];
endmodule

// File: rtl/pcs_hs_detect.sv
// Handshake detector: recognises the completion token from the output element.
// Assumes the token is presented on a single cycle with its strobe.
module pcs_hs_detect #(
    parameter int HS_W     = 8,
    parameter int HS_TOKEN = 222
) (
    input  logic            hs_valid,
    input  logic [HS_W-1:0] hs_word,
    output logic            done
);
    // Only the exact token with its strobe counts as completion.
    assign done = hs_valid && (hs_word == HS_W'(HS_TOKEN));
endmodule

// File: rtl/pcs_top.sv
// Dual-context program counter switch for one processing element.
// Serves collect and configure commands, rewrites the program counter only on a
// context change, holds configure commands while a block is busy, and ends a block
// on the completion token. Assumes one command per cycle on the command port.
module pcs_top
    import pcs_pkg::*;
#(
    parameter int IMEM_WORDS  = 512,
    parameter int DMEM_WORDS  = 512,
    parameter int FLAG_A_ADDR = 500,
    parameter int FLAG_B_ADDR = 501,
    parameter int STAT_ADDR   = 510,
    parameter int CTX_A_BASE  = 0,
    parameter int CTX_B_BASE  = 255,
    parameter int HS_W        = 8,
    parameter int HS_TOKEN    = 222
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_kind,
    input  logic [1:0]        cmd_code,
    input  logic              hs_valid,
    input  logic [HS_W-1:0]   hs_word,
    output logic [$clog2(IMEM_WORDS)-1:0] pc,
    output logic              pc_load,
    output logic              blk_busy,
    output logic              rpt_valid,
    output logic [1:0]        rpt_code,
    output logic              cfg_err
);
    localparam int PC_W = $clog2(IMEM_WORDS);
    localparam int AW   = $clog2(DMEM_WORDS);

    logic              code_known;
    logic [AW-1:0]     new_addr, sel_addr, unused_addr;
    logic              pend_known;
    logic [PC_W-1:0]   flag_val, stat_q;
    logic              tok_done;
    logic              pend_v;
    logic [CODE_W-1:0] pend_code, cur_mode, sel_code;
    logic              is_cfg, cfg_ok, cfg_bad, apply, switch_ctx;

    pcs_mode_decode #(.AW(AW), .FLAG_A_ADDR(FLAG_A_ADDR), .FLAG_B_ADDR(FLAG_B_ADDR))
        u_dec_new (.code(cmd_code), .known(code_known), .flag_addr(new_addr));

    pcs_mode_decode #(.AW(AW), .FLAG_A_ADDR(FLAG_A_ADDR), .FLAG_B_ADDR(FLAG_B_ADDR))
        u_dec_pend (.code(pend_code), .known(pend_known), .flag_addr(unused_addr));

    pcs_hs_detect #(.HS_W(HS_W), .HS_TOKEN(HS_TOKEN))
        u_hs (.hs_valid(hs_valid), .hs_word(hs_word), .done(tok_done));

    pcs_flag_store #(
        .AW(AW), .DW(PC_W), .FLAG_A_ADDR(FLAG_A_ADDR), .FLAG_B_ADDR(FLAG_B_ADDR),
        .STAT_ADDR(STAT_ADDR), .FLAG_A_VAL(CTX_A_BASE), .FLAG_B_VAL(CTX_B_BASE)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .rd_addr(sel_addr), .rd_data(flag_val),
        .st_we(blk_busy && tok_done), .st_wdata(PC_W'(cur_mode)), .st_q(stat_q)
    );

    // Classify the incoming command and choose between a fresh and a held configure.
    always_comb begin
        is_cfg     = cmd_valid && (cmd_e'(cmd_kind) == CMD_CONFIG);
        cfg_ok     = is_cfg && code_known;
        cfg_bad    = is_cfg && !code_known;
        apply      = !blk_busy && (cfg_ok || (pend_v && pend_known));
        sel_code   = cfg_ok ? cmd_code : pend_code;
        sel_addr   = cfg_ok ? new_addr
                   : (mode_e'(pend_code) == MODE_SML ? AW'(FLAG_B_ADDR) : AW'(FLAG_A_ADDR));
        switch_ctx = apply && (sel_code != cur_mode);
    end

    // Block state, program counter and held-command register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc        <= '0;
            pc_load   <= 1'b0;
            blk_busy  <= 1'b0;
            cur_mode  <= MODE_NONE;
            pend_v    <= 1'b0;
            pend_code <= MODE_NONE;
        end else begin
            pc_load <= 1'b0;
            if (apply) begin
                blk_busy <= 1'b1;
                pend_v   <= 1'b0;
                if (switch_ctx) begin
                    pc       <= flag_val;
                    pc_load  <= 1'b1;
                    cur_mode <= sel_code;
                end
            end else begin
                if (blk_busy && tok_done) blk_busy <= 1'b0;
                if (blk_busy && cfg_ok) begin
                    pend_v    <= 1'b1;
                    pend_code <= cmd_code;
                end
            end
        end
    end

    // Status report and error strobes toward the global controller.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rpt_valid <= 1'b0;
            rpt_code  <= '0;
            cfg_err   <= 1'b0;
        end else begin
            rpt_valid <= cmd_valid && (cmd_e'(cmd_kind) == CMD_COLLECT);
            if (cmd_valid && (cmd_e'(cmd_kind) == CMD_COLLECT))
                rpt_code <= stat_q[CODE_W-1:0];
            cfg_err <= cfg_bad;
        end
    end
endmodule

// File: rtl/pcs_checker.sv
// Checker: temporal properties of the program counter switch, bound to pcs_top.
// Assumes the default handshake token and context start words.
module pcs_checker #(
    parameter int PC_W     = 9,
    parameter int HS_W     = 8,
    parameter int HS_TOKEN = 222,
    parameter int A_BASE   = 0,
    parameter int B_BASE   = 255
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cmd_valid,
    input logic            cmd_kind,
    input logic            hs_valid,
    input logic [HS_W-1:0] hs_word,
    input logic [PC_W-1:0] pc,
    input logic            pc_load,
    input logic            blk_busy,
    input logic            rpt_valid,
    input logic            cfg_err
);
    AST_LOAD_AT_CONTEXT_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |-> (pc == PC_W'(A_BASE) || pc == PC_W'(B_BASE))); // R9
    AST_LOAD_STARTS_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |-> blk_busy); // R2
    AST_PC_ONLY_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !pc_load |-> $stable(pc)); // R3
    AST_ERR_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> !pc_load); // R4
    AST_ERR_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> $past(cmd_valid && cmd_kind)); // R4
    AST_BUSY_ENDS_ON_TOKEN: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $fell(blk_busy) |-> $past(hs_valid && hs_word == HS_W'(HS_TOKEN))); // R7
    AST_REPORT_AFTER_COLLECT: assert property (@(posedge clk) disable iff (!rst_n)
        rpt_valid |-> $past(cmd_valid && !cmd_kind)); // R5
endmodule

bind pcs_top pcs_checker #(
    .PC_W($clog2(IMEM_WORDS)), .HS_W(HS_W), .HS_TOKEN(HS_TOKEN),
    .A_BASE(CTX_A_BASE), .B_BASE(CTX_B_BASE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
    .hs_valid(hs_valid), .hs_word(hs_word), .pc(pc), .pc_load(pc_load),
    .blk_busy(blk_busy), .rpt_valid(rpt_valid), .cfg_err(cfg_err)
);

// File: tb/sim_pcs_top.sv
// Scoreboard bench: a driver task applies one cycle of stimulus and queues the expected
// outputs; a monitor pops one item after each clock edge and compares.
module sim_pcs_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0, cmd_kind = 1'b0;
    logic [1:0] cmd_code = 2'd0;
    logic       hs_valid = 1'b0;
    logic [7:0] hs_word = 8'd0;
    logic [8:0] pc;
    logic       pc_load, blk_busy, rpt_valid, cfg_err;
    logic [1:0] rpt_code;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 0;

    typedef struct {
        logic [8:0] pc;
        logic       busy, load, rv, err;
        logic [1:0] rc;
        string      tag;
    } exp_t;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    pcs_top u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
        .cmd_code(cmd_code), .hs_valid(hs_valid), .hs_word(hs_word), .pc(pc),
        .pc_load(pc_load), .blk_busy(blk_busy), .rpt_valid(rpt_valid),
        .rpt_code(rpt_code), .cfg_err(cfg_err)
    );

    // Monitor: compare each queued expectation shortly after the edge it belongs to.
    always @(posedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            #1;
            n_vec++;
            if (pc !== e.pc || blk_busy !== e.busy || pc_load !== e.load ||
                rpt_valid !== e.rv || cfg_err !== e.err || (e.rv && rpt_code !== e.rc)) begin
                n_bad++;
                $display("FAIL %s: got pc=%0d busy=%0b load=%0b rv=%0b rc=%0d err=%0b exp pc=%0d busy=%0b load=%0b rv=%0b rc=%0d err=%0b",
                    e.tag, pc, blk_busy, pc_load, rpt_valid, rpt_code, cfg_err,
                    e.pc, e.busy, e.load, e.rv, e.rc, e.err);
            end
        end
    end

    // Driver: one cycle of stimulus plus the outputs expected after that edge.
    task automatic cyc(input logic cv, input logic ck, input logic [1:0] cc,
                       input logic hv, input logic [7:0] hw,
                       input logic [8:0] epc, input logic eb, input logic el,
                       input logic erv, input logic [1:0] erc, input logic ee,
                       input string tag);
        exp_t e;
        @(negedge clk);
        cmd_valid = cv; cmd_kind = ck; cmd_code = cc;
        hs_valid = hv; hs_word = hw;
        e.pc = epc; e.busy = eb; e.load = el; e.rv = erv; e.rc = erc; e.err = ee; e.tag = tag;
        sb.push_back(e);
        @(posedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #50000;
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: state during reset
        cyc(0,0,0, 0,0,   0,0,0,0,0,0, "R1 in reset");
        rst_n = 1'b1;
        cyc(0,0,0, 0,0,   0,0,0,0,0,0, "R1 after reset");
        cyc(1,0,0, 0,0,   0,0,0,1,0,0, "R1 R5 collect status zero");
        cyc(1,1,3, 0,0,   0,0,0,0,0,1, "R4 code 3 flagged");
        cyc(0,0,0, 0,0,   0,0,0,0,0,0, "R4 error one cycle");
        cyc(0,0,0, 1,222, 0,0,0,0,0,0, "R7 token while idle ignored");
        cyc(1,1,2, 0,0,   255,1,1,0,0,0, "R2 switch to 8x8 context");
        cyc(0,0,0, 0,0,   255,1,0,0,0,0, "R2 load pulse one cycle");
        cyc(1,0,0, 0,0,   255,1,0,1,0,0, "R6 status unchanged at start");
        cyc(0,0,0, 1,221, 255,1,0,0,0,0, "R7 wrong token ignored");
        cyc(1,1,1, 0,0,   255,1,0,0,0,0, "R8 configure held while busy");
        cyc(1,1,2, 0,0,   255,1,0,0,0,0, "R8 newer held command replaces");
        cyc(1,1,0, 0,0,   255,1,0,0,0,1, "R4 code 0 while busy flagged");
        cyc(0,0,0, 1,222, 255,0,0,0,0,0, "R7 token ends block");
        cyc(0,0,0, 0,0,   255,1,0,0,0,0, "R8 R3 held same-mode start no load");
        cyc(1,0,0, 0,0,   255,1,0,1,2,0, "R6 status set at completion");
        cyc(0,0,0, 1,222, 255,0,0,0,0,0, "R7 token ends block 2");
        cyc(1,1,1, 0,0,   0,1,1,0,0,0, "R2 switch to 16x16 context");
        cyc(0,0,0, 1,222, 0,0,0,0,0,0, "R7 token ends block 3");
        cyc(1,1,1, 0,0,   0,1,0,0,0,0, "R3 same mode no reload");
        cyc(1,0,0, 1,222, 0,0,0,1,1,0, "R5 R6 collect with token");
        cyc(1,1,2, 0,0,   255,1,1,0,0,0, "R9 load 8x8 base");
        cyc(1,1,1, 1,222, 255,0,0,0,0,0, "R8 command with token held");
        cyc(0,0,0, 0,0,   0,1,1,0,0,0, "R8 held switch applied next cycle");
        cyc(0,0,0, 1,222, 0,0,0,0,0,0, "R7 token ends block 4");
        cyc(1,0,0, 0,0,   0,0,0,1,1,0, "R5 final status 16x16");
        cyc(0,0,0, 0,0,   0,0,0,0,0,0, "R5 report one cycle");
        @(negedge clk);
        @(negedge clk);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule